// File: doc/BRIEF.md
# Serial Bit-Clock and Frame-Clock Ratio Generator

This block turns a free-running master clock into the timing of a two-channel serial audio link. It gives a one-cycle bit-clock enable in the master clock domain and a frame-clock level. The serial engine beside it uses these when the link is master of its own clocks. The master-clock-to-sample-rate ratio comes from two control fields. A 3-bit shift code sets a power of two. A family select picks either the plain power-of-two series (512 down to 32) or the series of three times a power of two (384 down to 48).

A word-width flag picks 32 or 48 bit clocks per frame. 16-bit samples use 32; 20- and 24-bit samples use 48. The master clock is divided by the whole number ratio / bits-per-frame to form each bit period. A setting where that quotient is not a whole number of at least one is reported as bad, and the block keeps its clock outputs low. The outputs also stay low while the link is stopped, while its clock gate is closed, or while it is slave to external clocks. In slave mode the block also drops its drive-enable.

Top module: `bcg_clock_gen`

## Requirements
- R1: With `fam_tri` = 0 and shift codes 0, 1, 2, 3, 4, the ratio is 512, 256, 128, 64, 32. With 32 bits per frame, `bit_tick` then pulses once every 16, 8, 4, 2, 1 master cycles.
- R2: With `fam_tri` = 1 and shift codes 0, 1, 2, 3, the ratio is 384, 192, 96, 48. With 48 bits per frame, `bit_tick` then pulses once every 8, 4, 2, 1 master cycles.
- R3: `frame_len` reads 48 when `wide_word` = 1 and 32 when it is 0.
- R4: When ratio / `frame_len` is below one or not a whole number, `cfg_bad` is 1 and `bit_tick` and `frame_clk` stay 0. Example: any ratio of the power-of-two family with 48 bits, or ratio 48 with 32 bits.
- R5: Shift codes 5 to 7 with `fam_tri` = 0, and codes 4 to 7 with `fam_tri` = 1, set `cfg_bad` and keep both clock outputs 0.
- R6: `frame_clk` starts low and inverts at the same edge as every (`frame_len`/2)-th `bit_tick` pulse. So it is low for the first half frame and high for the second.
- R7: After an edge at which `run` = 0 or `clk_gate` = 1, `bit_tick` and `frame_clk` are 0.
- R8: While `slave_mode` = 1, `clk_oe` is 0 and, from the next edge on, `bit_tick` and `frame_clk` are 0. `clk_oe` is 1 otherwise.
- R9: When generation becomes enabled, counting restarts from phase zero: the first `bit_tick` follows the D-th enabled edge, where D is the divisor, and `frame_clk` starts low.
- R10: While `rst_n` = 0, `bit_tick` and `frame_clk` are 0, whatever `run` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | master clock, all state on its rising edge |
| rst_n | input | 1 | synchronous active-low reset |
| run | input | 1 | 1 lets the generator count |
| clk_gate | input | 1 | 1 halts generation and parks outputs low |
| slave_mode | input | 1 | 1 when clocks come from outside the link |
| fam_tri | input | 1 | ratio family: 0 power of two, 1 three times a power of two |
| shift_code | input | MULT_W (3) | right-shift applied to the family's largest ratio |
| wide_word | input | 1 | 1 for 48 bit clocks per frame (20/24-bit samples) |
| bit_tick | output | 1 | one-cycle pulse at the end of each bit period |
| frame_clk | output | 1 | frame (left/right) clock level |
| clk_oe | output | 1 | 1 when this block may drive the link clocks |
| cfg_bad | output | 1 | 1 when the ratio setting is not usable |
| frame_len | output | FLEN_W (6) | bit clocks per frame for the serial engine |

## Verification
The hardest case to reach from the ports is a restart in the middle of a bit period. Gating or stopping the link has to throw away a partly counted divisor and half-frame count, and the next enabled edge has to begin again at phase zero. The bench runs a slow divisor for a count of cycles that is not a multiple of the divisor, then closes the gate, drops `run` or enters slave mode. After each, it checks the exact cycle of the first pulse and the low first half of the frame. The sweep covers every family, code and width combination, and works out each divisor and each frame-clock level per cycle by arithmetic.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
   // ratio family selected by the base-rate bit
   typedef enum logic {
      FAM_POW2 = 1'b0,
      FAM_TRI  = 1'b1
   } bcg_family_e;

   // true when v is a nonzero power of two
   function automatic bit bcg_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/bcg_ratio_dec.sv
module bcg_ratio_dec
   import bcg_pkg::*;
#(
   parameter int unsigned MULT_W      = 3,
   parameter int unsigned POW2_TOP    = 512,
   parameter int unsigned TRI_TOP     = 384,
   parameter int unsigned POW2_CODES  = 5,
   parameter int unsigned TRI_CODES   = 4,
   parameter int unsigned NARROW_BITS = 32,
   parameter int unsigned WIDE_BITS   = 48,
   parameter int unsigned DIV_W       = 5
) (
   input  bcg_family_e       fam,
   input  logic [MULT_W-1:0] code,
   input  logic              wide,
   output logic [DIV_W-1:0]  div,
   output logic              ok
);
   localparam int unsigned RATIO_W = $clog2(POW2_TOP + 1);

   logic [RATIO_W-1:0] ratio;
   logic [RATIO_W-1:0] q_n, q_w, r_n, r_w, q_sel, r_sel;
   logic [MULT_W:0]    code_x;
   logic               code_ok;

   always_comb begin
      code_x = {1'b0, code};
      if (fam == FAM_TRI) begin
         ratio   = RATIO_W'(TRI_TOP) >> code;
         code_ok = code_x < (MULT_W + 1)'(TRI_CODES);
      end else begin
         ratio   = RATIO_W'(POW2_TOP) >> code;
         code_ok = code_x < (MULT_W + 1)'(POW2_CODES);
      end
      q_n   = ratio / RATIO_W'(NARROW_BITS);
      r_n   = ratio % RATIO_W'(NARROW_BITS);
      q_w   = ratio / RATIO_W'(WIDE_BITS);
      r_w   = ratio % RATIO_W'(WIDE_BITS);
      q_sel = wide ? q_w : q_n;
      r_sel = wide ? r_w : r_n;
      ok    = code_ok && (q_sel != '0) && (r_sel == '0);
      div   = ok ? DIV_W'(q_sel) : DIV_W'(1);
   end
endmodule

// File: rtl/bcg_bit_div.sv
module bcg_bit_div #(
   parameter int unsigned DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             wrap,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign wrap = en && (cnt == div - DIV_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (wrap) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + DIV_W'(1);
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/bcg_frame_cnt.sv
module bcg_frame_cnt #(
   parameter int unsigned HALF_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              step,
   input  logic [HALF_W-1:0] half_len,
   output logic              level
);
   logic [HALF_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt   <= '0;
         level <= 1'b0;
      end else if (step) begin
         if (cnt == half_len - HALF_W'(1)) begin
            cnt   <= '0;
            level <= ~level;
         end else begin
            cnt <= cnt + HALF_W'(1);
         end
      end
   end
endmodule

// File: rtl/bcg_clock_gen.sv
module bcg_clock_gen
   import bcg_pkg::*;
#(
   parameter int unsigned MULT_W      = 3,
   parameter int unsigned POW2_TOP    = 512,
   parameter int unsigned TRI_TOP     = 384,
   parameter int unsigned POW2_CODES  = 5,
   parameter int unsigned TRI_CODES   = 4,
   parameter int unsigned NARROW_BITS = 32,
   parameter int unsigned WIDE_BITS   = 48,
   localparam int unsigned FLEN_W     = $clog2(WIDE_BITS + 1)
) (
   input  logic              mclk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              clk_gate,
   input  logic              slave_mode,
   input  logic              fam_tri,
   input  logic [MULT_W-1:0] shift_code,
   input  logic              wide_word,
   output logic              bit_tick,
   output logic              frame_clk,
   output logic              clk_oe,
   output logic              cfg_bad,
   output logic [FLEN_W-1:0] frame_len
);
   localparam int unsigned DIV_W  = $clog2(POW2_TOP / NARROW_BITS + 1);
   localparam int unsigned HALF_W = $clog2(WIDE_BITS / 2 + 1);

   // elaboration-time parameter checks
   if (!bcg_is_pow2(POW2_TOP)) begin : g_chk_pow2
      $error("POW2_TOP must be a power of two");
   end
   if ((TRI_TOP % 3 != 0) || !bcg_is_pow2(TRI_TOP / 3) || (TRI_TOP >= POW2_TOP)) begin : g_chk_tri
      $error("TRI_TOP must be three times a power of two below POW2_TOP");
   end
   if ((NARROW_BITS % 2 != 0) || (WIDE_BITS % 2 != 0) || (WIDE_BITS <= NARROW_BITS)) begin : g_chk_bits
      $error("frame lengths must be even and WIDE_BITS above NARROW_BITS");
   end
   if ((POW2_CODES > (1 << MULT_W)) || (TRI_CODES > POW2_CODES)) begin : g_chk_codes
      $error("code counts do not fit the shift field");
   end

   logic             cfg_ok;
   logic [DIV_W-1:0] div;
   logic             active;
   logic             wrap;
   logic [HALF_W-1:0] half_len;

   bcg_ratio_dec #(
      .MULT_W(MULT_W), .POW2_TOP(POW2_TOP), .TRI_TOP(TRI_TOP),
      .POW2_CODES(POW2_CODES), .TRI_CODES(TRI_CODES),
      .NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS), .DIV_W(DIV_W)
   ) u_dec (
      .fam  (bcg_family_e'(fam_tri)),
      .code (shift_code),
      .wide (wide_word),
      .div  (div),
      .ok   (cfg_ok)
   );

   assign active    = run && !clk_gate && !slave_mode && cfg_ok;
   assign cfg_bad   = !cfg_ok;
   assign clk_oe    = !slave_mode;
   assign frame_len = wide_word ? FLEN_W'(WIDE_BITS) : FLEN_W'(NARROW_BITS);
   assign half_len  = wide_word ? HALF_W'(WIDE_BITS / 2) : HALF_W'(NARROW_BITS / 2);

   bcg_bit_div #(.DIV_W(DIV_W)) u_div (
      .clk   (mclk),
      .rst_n (rst_n),
      .en    (active),
      .div   (div),
      .wrap  (wrap),
      .tick  (bit_tick)
   );

   bcg_frame_cnt #(.HALF_W(HALF_W)) u_frame (
      .clk      (mclk),
      .rst_n    (rst_n),
      .en       (active),
      .step     (wrap),
      .half_len (half_len),
      .level    (frame_clk)
   );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
   parameter int unsigned FLEN_W      = 6,
   parameter int unsigned NARROW_BITS = 32,
   parameter int unsigned WIDE_BITS   = 48
) (
   input logic              mclk,
   input logic              rst_n,
   input logic              run,
   input logic              clk_gate,
   input logic              slave_mode,
   input logic              cfg_bad,
   input logic              bit_tick,
   input logic              frame_clk,
   input logic [FLEN_W-1:0] frame_len
);
   AST_IDLE_LOW: assert property (@(posedge mclk) disable iff (!rst_n)
      (!run || clk_gate) |=> (!bit_tick && !frame_clk)); // R7

   AST_SLAVE_QUIET: assert property (@(posedge mclk) disable iff (!rst_n)
      slave_mode |=> (!bit_tick && !frame_clk)); // R8

   AST_BAD_SILENT: assert property (@(posedge mclk) disable iff (!rst_n)
      cfg_bad |=> (!bit_tick && !frame_clk)); // R4

   AST_FRAME_LEN: assert property (@(posedge mclk) disable iff (!rst_n)
      (frame_len == FLEN_W'(NARROW_BITS)) || (frame_len == FLEN_W'(WIDE_BITS))); // R3

   AST_FRAME_ON_TICK: assert property (@(posedge mclk) disable iff (!rst_n)
      (!$stable(frame_clk) && $past(run && !clk_gate && !slave_mode && !cfg_bad)) |-> bit_tick); // R6
endmodule

bind bcg_clock_gen bcg_checker #(
   .FLEN_W(FLEN_W), .NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)
) u_chk (
   .mclk       (mclk),
   .rst_n      (rst_n),
   .run        (run),
   .clk_gate   (clk_gate),
   .slave_mode (slave_mode),
   .cfg_bad    (cfg_bad),
   .bit_tick   (bit_tick),
   .frame_clk  (frame_clk),
   .frame_len  (frame_len)
);

// File: tb/sim_bcg_clock_gen.sv
module sim_bcg_clock_gen;
   logic       mclk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       clk_gate = 1'b0;
   logic       slave_mode = 1'b0;
   logic       fam_tri = 1'b0;
   logic [2:0] shift_code = 3'd0;
   logic       wide_word = 1'b0;
   logic       bit_tick, frame_clk, clk_oe, cfg_bad;
   logic [5:0] frame_len;

   int checks = 0;
   int errors = 0;

   always #2 mclk = ~mclk;

   bcg_clock_gen u0 (
      .mclk(mclk), .rst_n(rst_n), .run(run), .clk_gate(clk_gate),
      .slave_mode(slave_mode), .fam_tri(fam_tri), .shift_code(shift_code),
      .wide_word(wide_word), .bit_tick(bit_tick), .frame_clk(frame_clk),
      .clk_oe(clk_oe), .cfg_bad(cfg_bad), .frame_len(frame_len)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // divisor from the requirements; 0 means unusable setting
   function automatic int exp_div(input int fam, input int code, input int wide);
      int ratio, bpf;
      if (fam == 0 && code > 4) return 0;
      if (fam == 1 && code > 3) return 0;
      ratio = (fam == 1) ? 384 / (1 << code) : 512 / (1 << code);
      bpf   = wide ? 48 : 32;
      if (ratio < bpf || (ratio % bpf) != 0) return 0;
      return ratio / bpf;
   endfunction

   // n enabled edges from phase zero; compares both outputs every cycle
   task automatic follow(input int n, input int d, input int bpf, input string req);
      int bad = 0;
      int first_bad = -1;
      for (int i = 1; i <= n; i++) begin
         logic eb, ef;
         @(posedge mclk);
         @(negedge mclk);
         eb = (d > 0) && (i % d == 0);
         ef = (d > 0) ? (((i / d) / (bpf / 2)) % 2 == 1) : 1'b0;
         if (bit_tick !== eb || frame_clk !== ef) begin
            bad++;
            if (first_bad < 0) first_bad = i;
         end
      end
      chk(bad == 0, req, first_bad, -1);
   endtask

   task automatic quiet(input int n, input string req);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge mclk);
         @(negedge mclk);
         if (bit_tick !== 1'b0 || frame_clk !== 1'b0) bad++;
      end
      chk(bad == 0, req, bad, 0);
   endtask

   initial begin
      #(4 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int d, bpf;
      // R10: reset dominates run
      run = 1'b1;
      fam_tri = 1'b0; shift_code = 3'd4; wide_word = 1'b0;
      quiet(4, "R10 outputs in reset");
      run = 1'b0;
      rst_n = 1'b1;
      @(negedge mclk);

      // full sweep of family, code and width
      for (int f = 0; f < 2; f++) begin
         for (int w = 0; w < 2; w++) begin
            for (int c = 0; c < 8; c++) begin
               string req;
               run = 1'b0;
               fam_tri = f[0]; shift_code = c[2:0]; wide_word = w[0];
               @(posedge mclk);
               @(negedge mclk);
               d   = exp_div(f, c, w);
               bpf = w ? 48 : 32;
               if ((f == 0 && c > 4) || (f == 1 && c > 3)) req = "R5";
               else if (d == 0) req = "R4";
               else if (f == 1) req = "R2 R6";
               else req = "R1 R6";
               chk(cfg_bad == (d == 0), req, int'(cfg_bad), int'(d == 0));
               chk(frame_len == 6'(bpf), "R3", int'(frame_len), bpf);
               run = 1'b1;
               follow((d > 0) ? 2 * bpf * d : 40, d, bpf, req);
            end
         end
      end
      run = 1'b0;
      @(negedge mclk);

      // gate mid-period, then restart from phase zero
      fam_tri = 1'b0; shift_code = 3'd0; wide_word = 1'b0;  // divisor 16
      run = 1'b1;
      follow(37, 16, 32, "R1");
      clk_gate = 1'b1;
      quiet(20, "R7 gate closed");
      clk_gate = 1'b0;
      follow(2 * 32 * 16, 16, 32, "R9 restart after gate");

      // stop mid-period with wide frame
      fam_tri = 1'b1; shift_code = 3'd0; wide_word = 1'b1;  // divisor 8
      run = 1'b0;
      quiet(3, "R7 run low");
      run = 1'b1;
      follow(300, 8, 48, "R2");
      run = 1'b0;
      quiet(10, "R7 stopped mid period");
      run = 1'b1;
      follow(2 * 48 * 8, 8, 48, "R9 restart after stop");

      // slave mode
      chk(clk_oe == 1'b1, "R8 master drives", int'(clk_oe), 1);
      fam_tri = 1'b0; shift_code = 3'd2; wide_word = 1'b0;  // divisor 4
      run = 1'b0;
      @(negedge mclk);
      run = 1'b1;
      follow(51, 4, 32, "R1");
      slave_mode = 1'b1;
      #0;
      chk(clk_oe == 1'b0, "R8 slave releases", int'(clk_oe), 0);
      quiet(30, "R8 slave quiet");
      slave_mode = 1'b0;
      follow(2 * 32 * 4, 4, 32, "R9 restart after slave");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule